// File: doc/BRIEF.md
# Oscillator Frequency Acquisition Window Counter

This block helps a phase-locked loop find its lock-in range. It measures the loop's oscillator against a stable reference clock and then tells the loop which way to move. A down-counter runs on the oscillator clock. Before each measurement it is loaded with a start value chosen by a standard-select code. It counts down for a gate interval that lasts a programmable number of reference cycles. The residual count is then compared with a programmable window:

- A residual above the window means the oscillator is too slow, so the block raises a pump-up command.
- A residual below the window means the oscillator is too fast, so the block raises a pump-down command.
- A residual inside the window means the loop is in range, so the block reports in-window status.

The low four bits of the residual are latched as a fine frequency-error code for an external converter. A mute output can follow the out-of-window condition.

All gate timing and all decisions are made in the reference domain. The counter lives in the oscillator domain. The gate crosses into that domain through a two-flop synchronizer. The captured residual comes back through a toggle handshake. A new measurement starts as soon as the previous one has been evaluated, so the block cycles continuously. The standard select and the window bounds are expected to be quasi-static.

Top module: `freq_acq_window`

## Requirements
- R1: At the start of each measurement the down-counter holds the start value 400 + 100 * std_sel (default parameters), where std_sel is the 2-bit standard code.
- R2: While the gate is open the counter drops by one on every oscillator rising edge. The gate stays open for exactly max(gate_len, 1) reference cycles. Evaluation happens only after the gate has closed.
- R3: A residual greater than win_hi gives pump_up=1, pump_dn=0 and in_window=0.
- R4: A residual with win_lo <= residual <= win_hi (both bounds inclusive) gives in_window=1 with pump_up=0 and pump_dn=0.
- R5: A residual less than win_lo gives pump_dn=1, pump_up=0 and in_window=0.
- R6: The counter saturates at zero. If a decrement is requested at zero, the result is treated as below the window (pump_dn=1), even when win_lo is 0. A residual that reaches exactly zero without such a request is compared normally.
- R7: afc_code equals bits [3:0] of the residual from the latest evaluation.
- R8: mute is 1 exactly when auto_mute_en is 1 and in_window is 0.
- R9: Measurements repeat without pause. Pump, status and afc outputs hold their values between evaluations.
- R10: After reset, pump_up, pump_dn, afc_code and in_window are 0. The first evaluation result appears within gate_len + 8 reference cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all timing and decisions |
| osc_clk | input | 1 | Oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| std_sel | input | 2 | Standard code selecting the counter start value |
| gate_len | input | 8 | Gate length in reference cycles (0 acts as 1) |
| win_lo | input | 12 | Lower window bound, inclusive |
| win_hi | input | 12 | Upper window bound, inclusive |
| auto_mute_en | input | 1 | Lets an out-of-window result drive mute |
| pump_up | output | 1 | Raise oscillator frequency |
| pump_dn | output | 1 | Lower oscillator frequency |
| in_window | output | 1 | Latest residual lies inside the window |
| afc_code | output | 4 | Low four bits of the latest residual |
| mute | output | 1 | Audio mute request |

## Verification
The residual is an exact function of the start value, the gate length and the oscillator-to-reference ratio. A wrong start value, a wrong gate length or a lost decrement therefore shows up on afc_code and on the pump/window outputs at the very first evaluation, about gate_len + 5 reference cycles after reset. A broken handshake or a broken gate sequencer shows up differently: either no evaluation appears within the latency bound, or the outputs jump between values instead of settling on one repeated result. A wrong comparison or a wrong saturation rule flips a pump or the window flag in the window-edge and zero-residual cases.

// File: rtl/fawc_pkg.sv
package fawc_pkg;

  typedef enum logic [1:0] {
    GS_LOAD = 2'd0,
    GS_OPEN = 2'd1,
    GS_WAIT = 2'd2
  } gate_state_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic inw;
  } verdict_t;

  // start value for a standard code
  function automatic logic [11:0] start_value(input logic [1:0] code,
                                              input int unsigned base,
                                              input int unsigned step);
    int unsigned v;
    v = base + step * int'(code);
    return v[11:0];
  endfunction

  // window decision for a residual; underflow always counts as too fast
  function automatic verdict_t judge(input logic [11:0] resid,
                                     input logic uflow,
                                     input logic [11:0] lo,
                                     input logic [11:0] hi);
    verdict_t v;
    v = '0;
    if (uflow || resid < lo) v.dn = 1'b1;
    else if (resid > hi)     v.up = 1'b1;
    else                     v.inw = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fawc_sync.sv
module fawc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fawc_gate_ctrl.sv
module fawc_gate_ctrl
  import fawc_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic [GW-1:0] gate_len,
  input  logic          eval_evt,
  output logic          gate_open
);
  gate_state_e   st_q;
  logic [GW-1:0] gcnt_q;
  logic [GW-1:0] glen;

  assign glen = (gate_len == '0) ? GW'(1) : gate_len;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= GS_LOAD;
      gcnt_q    <= '0;
      gate_open <= 1'b0;
    end else begin
      unique case (st_q)
        GS_LOAD: begin
          gate_open <= 1'b1;
          gcnt_q    <= GW'(1);
          st_q      <= GS_OPEN;
        end
        GS_OPEN: begin
          if (gcnt_q >= glen) begin
            gate_open <= 1'b0;
            st_q      <= GS_WAIT;
          end else begin
            gcnt_q <= gcnt_q + GW'(1);
          end
        end
        GS_WAIT: begin
          if (eval_evt) begin
            gate_open <= 1'b1;
            gcnt_q    <= GW'(1);
            st_q      <= GS_OPEN;
          end
        end
        default: st_q <= GS_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/fawc_osc_counter.sv
module fawc_osc_counter
  import fawc_pkg::*;
#(
  parameter int CW         = 12,
  parameter int SW         = 2,
  parameter int START_BASE = 400,
  parameter int START_STEP = 100
) (
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          gate_open,
  input  logic [SW-1:0] std_sel,
  output logic          gate_sync,
  output logic [CW-1:0] osc_cnt,
  output logic [CW-1:0] cap_cnt,
  output logic          cap_uf,
  output logic          cap_tgl
);
  logic          gate_prev;
  logic          uf_q;
  logic [CW-1:0] start_v;

  assign start_v = CW'(start_value(2'(std_sel), START_BASE, START_STEP));

  fawc_sync #(.STAGES(2), .W(1)) u_gate_sync (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .d     (gate_open),
    .q     (gate_sync)
  );

  // counter: preset while the gate is closed, saturating count-down while open
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_cnt <= '0;
      uf_q    <= 1'b0;
    end else if (!gate_sync) begin
      osc_cnt <= start_v;
      uf_q    <= 1'b0;
    end else if (osc_cnt == '0) begin
      uf_q    <= 1'b1;
    end else begin
      osc_cnt <= osc_cnt - CW'(1);
    end
  end

  // capture on the gate's falling edge and flip the handshake toggle
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_prev <= 1'b0;
      cap_cnt   <= '0;
      cap_uf    <= 1'b0;
      cap_tgl   <= 1'b0;
    end else begin
      gate_prev <= gate_sync;
      if (gate_prev && !gate_sync) begin
        cap_cnt <= osc_cnt;
        cap_uf  <= uf_q;
        cap_tgl <= ~cap_tgl;
      end
    end
  end
endmodule

// File: rtl/fawc_eval.sv
module fawc_eval
  import fawc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          cap_tgl,
  input  logic [CW-1:0] cap_cnt,
  input  logic          cap_uf,
  input  logic [CW-1:0] win_lo,
  input  logic [CW-1:0] win_hi,
  output logic          eval_evt,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          in_window,
  output logic [3:0]    afc_code
);
  logic     tgl_s;
  logic     tgl_prev;
  verdict_t vd;

  fawc_sync #(.STAGES(2), .W(1)) u_tgl_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (cap_tgl),
    .q     (tgl_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tgl_prev <= 1'b0;
    else        tgl_prev <= tgl_s;
  end

  assign eval_evt = tgl_s ^ tgl_prev;
  assign vd = judge(12'(cap_cnt), cap_uf, 12'(win_lo), 12'(win_hi));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_up   <= 1'b0;
      pump_dn   <= 1'b0;
      in_window <= 1'b0;
      afc_code  <= '0;
    end else if (eval_evt) begin
      pump_up   <= vd.up;
      pump_dn   <= vd.dn;
      in_window <= vd.inw;
      afc_code  <= cap_cnt[3:0];
    end
  end
endmodule

// File: rtl/freq_acq_window.sv
module freq_acq_window #(
  parameter int CW         = 12,
  parameter int GW         = 8,
  parameter int SW         = 2,
  parameter int START_BASE = 400,
  parameter int START_STEP = 100
) (
  input  logic          ref_clk,
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic [SW-1:0] std_sel,
  input  logic [GW-1:0] gate_len,
  input  logic [CW-1:0] win_lo,
  input  logic [CW-1:0] win_hi,
  input  logic          auto_mute_en,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          in_window,
  output logic [3:0]    afc_code,
  output logic          mute
);
  logic          gate_open;
  logic          gate_sync;
  logic          eval_evt;
  logic [CW-1:0] osc_cnt;
  logic [CW-1:0] cap_cnt;
  logic          cap_uf;
  logic          cap_tgl;

  fawc_gate_ctrl #(.GW(GW)) u_gate (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .gate_len  (gate_len),
    .eval_evt  (eval_evt),
    .gate_open (gate_open)
  );

  fawc_osc_counter #(
    .CW(CW), .SW(SW), .START_BASE(START_BASE), .START_STEP(START_STEP)
  ) u_cnt (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .gate_open (gate_open),
    .std_sel   (std_sel),
    .gate_sync (gate_sync),
    .osc_cnt   (osc_cnt),
    .cap_cnt   (cap_cnt),
    .cap_uf    (cap_uf),
    .cap_tgl   (cap_tgl)
  );

  fawc_eval #(.CW(CW)) u_eval (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .cap_tgl   (cap_tgl),
    .cap_cnt   (cap_cnt),
    .cap_uf    (cap_uf),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .eval_evt  (eval_evt),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .in_window (in_window),
    .afc_code  (afc_code)
  );

  assign mute = auto_mute_en & ~in_window;
endmodule

// File: rtl/fawc_chk.sv
module fawc_chk #(
  parameter int CW = 12
) (
  input logic          ref_clk,
  input logic          osc_clk,
  input logic          rst_n,
  input logic          pump_up,
  input logic          pump_dn,
  input logic          in_window,
  input logic [3:0]    afc_code,
  input logic          eval_evt,
  input logic          gate_open,
  input logic          gate_sync,
  input logic [CW-1:0] osc_cnt,
  input logic          cap_uf
);
  AST_PUMP_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R3

  AST_INWIN_NO_PUMP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    in_window |-> (!pump_up && !pump_dn)); // R4

  AST_HOLD_BETWEEN_EVAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !eval_evt |=> $stable({pump_up, pump_dn, in_window, afc_code})); // R9

  AST_EVAL_AFTER_CLOSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    eval_evt |-> !gate_open); // R2

  AST_UNDERFLOW_BELOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (eval_evt && cap_uf) |=> pump_dn); // R6

  AST_NO_WRAP: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (gate_sync && osc_cnt == '0) |=> (osc_cnt == '0)); // R6
endmodule

bind freq_acq_window fawc_chk #(.CW(CW)) u_chk (
  .ref_clk   (ref_clk),
  .osc_clk   (osc_clk),
  .rst_n     (rst_n),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .in_window (in_window),
  .afc_code  (afc_code),
  .eval_evt  (eval_evt),
  .gate_open (gate_open),
  .gate_sync (gate_sync),
  .osc_cnt   (osc_cnt),
  .cap_uf    (cap_uf)
);

// File: tb/freq_acq_window_tb.sv
`timescale 1ns/1ps
module freq_acq_window_tb;
  localparam int CW = 12;
  localparam int GW = 8;
  localparam int SW = 2;

  logic          ref_clk = 1'b0;
  logic          osc_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic [SW-1:0] std_sel = '0;
  logic [GW-1:0] gate_len = GW'(10);
  logic [CW-1:0] win_lo = '0;
  logic [CW-1:0] win_hi = '0;
  logic          auto_mute_en = 1'b0;
  logic          pump_up, pump_dn, in_window, mute;
  logic [3:0]    afc_code;

  int  vectors = 0;
  int  misses  = 0;
  int  ratio   = 4;
  bit  finished = 1'b0;

  freq_acq_window u_dut (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .std_sel(std_sel), .gate_len(gate_len), .win_lo(win_lo), .win_hi(win_hi),
    .auto_mute_en(auto_mute_en), .pump_up(pump_up), .pump_dn(pump_dn),
    .in_window(in_window), .afc_code(afc_code), .mute(mute)
  );

  always #10 ref_clk = ~ref_clk;  // 50 MHz

  // oscillator: 'ratio' rising edges per reference period, offset by 1 ns
  initial begin
    forever begin
      @(posedge ref_clk);
      #1 osc_clk = 1'b1;
      for (int k = 1; k < 2 * ratio; k++) begin
        #(10.0 / ratio) osc_clk = ~osc_clk;
      end
    end
  end

  function automatic logic [7:0] pack_out(bit up, bit dn, bit inw, logic [3:0] afc, bit mu);
    return {up, dn, inw, afc, mu};
  endfunction

  // behavioural expectation for one configuration
  function automatic logic [7:0] expect_result(int std, int g, int n, int lo, int hi, bit am);
    int start_v, steps, resid;
    bit uf, up, dn, inw;
    start_v = 400 + 100 * std;          // R1
    steps   = ((g == 0) ? 1 : g) * n;   // R2
    uf      = steps > start_v;
    resid   = uf ? 0 : start_v - steps;
    up = 0; dn = 0; inw = 0;
    if (uf) dn = 1;                     // R6
    else if (resid < lo) dn = 1;        // R5
    else if (resid > hi) up = 1;        // R3
    else inw = 1;                       // R4
    return pack_out(up, dn, inw, 4'(resid % 16), am && !inw); // R7 R8
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got up/dn/inw/afc/mute=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic run_phase(string tag, int std, int g, int n, int lo, int hi, bit am);
    logic [7:0] exp, init, got;
    bit seen;
    int lat;
    @(negedge ref_clk);
    rst_n = 1'b0;
    std_sel = SW'(std); gate_len = GW'(g); win_lo = CW'(lo); win_hi = CW'(hi);
    auto_mute_en = am; ratio = n;
    repeat (3) @(negedge ref_clk);
    init = pack_out(0, 0, 0, 4'd0, am);
    got  = pack_out(pump_up, pump_dn, in_window, afc_code, mute);
    check({"R10 reset state ", tag}, got, init);
    exp = expect_result(std, g, n, lo, hi, am);
    rst_n = 1'b1;
    seen = 0; lat = 0;
    for (int c = 1; c <= 3 * (g + 12) + 10; c++) begin
      @(negedge ref_clk);
      got = pack_out(pump_up, pump_dn, in_window, afc_code, mute);
      if (!seen && got === init) begin
        vectors++;                      // still waiting for the first result
      end else begin
        if (!seen) lat = c;
        seen = 1;
        check({tag, " R9 held"}, got, exp);
      end
    end
    vectors++;
    if (!seen || lat > g + 8) begin
      misses++;
      $display("FAIL R10 %s: first result latency %0d (seen=%0d) expected <= %0d", tag, lat, seen, g + 8);
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R4 R7 R8: residual 200 inside [190,210], mute off
    run_phase("R4 in-window", 0, 50, 4, 190, 210, 1'b1);
    // R3 R1: start 500, 100 steps -> 400 above window, mute on
    run_phase("R3 too-slow", 1, 50, 2, 190, 210, 1'b1);
    // R5: 300 steps -> 100 below window, mute disabled
    run_phase("R5 too-fast", 0, 60, 5, 190, 210, 1'b0);
    // R4: residual 400 equals lower bound
    run_phase("R4 low-bound", 2, 50, 4, 400, 450, 1'b1);
    // R4: residual 400 equals upper bound
    run_phase("R4 high-bound", 3, 75, 4, 350, 400, 1'b1);
    // R3: residual one above upper bound
    run_phase("R3 above-bound", 3, 75, 4, 350, 399, 1'b1);
    // R6: 480 steps from 400 saturate, below even with lo=0
    run_phase("R6 saturate", 0, 120, 4, 0, 100, 1'b1);
    // R6: exactly reaching zero is compared normally
    run_phase("R6 exact-zero", 0, 100, 4, 0, 100, 1'b1);
    // R2: gate_len 0 behaves as one cycle; 1 step -> 499 above window
    run_phase("R2 gate-zero", 1, 0, 1, 0, 450, 1'b0);
    // R7 R9: odd residual 537 = 700 - 163 at ratio 1, in window
    run_phase("R7 afc-odd", 3, 163, 1, 500, 600, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule